// File: doc/BRIEF.md
# PWM Fault Output Override

This block sits between a free-running PWM generator and the chip's output pads. Each submodule has three PWM outputs: A, B and X. For every output, the block decides whether the output runs normally or is held in a programmed safe state. It makes that decision from eight fault-active lines and a per-output mask that selects which faults act on that output. The generator is never stopped. Only the value that reaches the pad is replaced.

Each fault line is formed inside the block as the OR of two inputs: the raw, unfiltered, active-high fault input and the latched disable from the recovery logic. The raw input therefore reaches the pads through a purely combinational path, with no filter, no register and no clock on the way. Outputs go safe even when the filter is still counting or the module clock has stopped.

When a masked-in fault is active, a 2-bit safe-state code per output selects one of three results: forced low, forced high, or pad released. A forced level passes through the output's polarity inversion. A released pad does not. Masks, safe-state codes and polarity bits arrive as static register values from outside the block. The reset value of every mask bit is all ones, so after reset every fault acts on every output.

Top module: `pwm_ovr_top`

## Requirements
- R1: When no masked-in fault is active for output o, pin_o[o] equals pwm_raw_i[o] XOR pol_inv_i[o] and pin_oe_o[o] is 1. Output index o = sub*3 + ch, with ch 0 = A, 1 = B, 2 = X.
- R2: Output o is overridden when any fault f is active and dis_mask_i[o*8+f] is 1. A single active masked fault is enough.
- R3: An active fault whose mask bit for output o is 0 has no effect on pin_o[o] or pin_oe_o[o].
- R4: Fault f is active when flt_raw_i[f] is 1 or flt_hold_i[f] is 1. Each source alone overrides a masked output.
- R5: While overridden with safe code fs_code_i[2o+1:2o] = 2'b00, the level is forced to 0 before polarity: pin_o[o] = pol_inv_i[o] and pin_oe_o[o] = 1.
- R6: While overridden with safe code 2'b01, the level is forced to 1 before polarity: pin_o[o] = NOT pol_inv_i[o] and pin_oe_o[o] = 1.
- R7: While overridden with safe code 2'b10 or 2'b11, pin_oe_o[o] is 0 and pin_o[o] is 0 whatever the polarity bit.
- R8: The override takes effect and releases combinationally. Outputs follow a change on flt_raw_i between clock edges, with no edge needed.
- R9: While an output is overridden, changes on its raw PWM input do not reach the pin.
- R10: With the reset configuration (every mask bit 1, code 00, polarity 0), any single active fault forces every output to 0 with its enable asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pwm_raw_i | input | NUM_SUB*3 | Raw generator outputs, index sub*3+ch |
| flt_raw_i | input | NUM_FAULT | Unfiltered fault inputs, active high |
| flt_hold_i | input | NUM_FAULT | Latched disables from the recovery logic |
| dis_mask_i | input | NUM_SUB*3*NUM_FAULT | Per-output fault mask, bit o*NUM_FAULT+f |
| fs_code_i | input | NUM_SUB*3*2 | Per-output safe-state code |
| pol_inv_i | input | NUM_SUB*3 | Per-output polarity inversion |
| pin_o | output | NUM_SUB*3 | Pad value |
| pin_oe_o | output | NUM_SUB*3 | Pad output enable |

## Verification
The bench applies the polarity bit to a forced level and checks that the pad shows the opposite of the code. A design that inverted after a tristate decision, or ignored polarity on forced levels, would show the wrong pad level or a driven pad where it should be released. The bench then sets an active fault in a mask position that is cleared and checks that the pad is untouched, which catches a mask index off by one output or one fault. It drives each fault source alone, which catches a block that honours only the latched disable. Between clock edges it raises and drops the raw fault, and it toggles the raw PWM while a fault holds, which exposes any register on the disable path and any leakage of generator activity into a held pin.

// File: rtl/pwm_ovr_pkg.sv
package pwm_ovr_pkg;
  localparam int unsigned CH_PER_SUB = 3;
  localparam int unsigned FS_W       = 2;

  typedef enum logic [FS_W-1:0] {
    FS_LOW   = 2'b00,
    FS_HIGH  = 2'b01,
    FS_REL_A = 2'b10,
    FS_REL_B = 2'b11
  } fs_code_e;
endpackage

// File: rtl/pwm_ovr_fault_sel.sv
module pwm_ovr_fault_sel #(
  parameter int unsigned NUM_FAULT = 8
) (
  input  logic [NUM_FAULT-1:0] flt_act_i,
  input  logic [NUM_FAULT-1:0] mask_i,
  output logic                 hit_o
);
  assign hit_o = |(flt_act_i & mask_i);
endmodule

// File: rtl/pwm_ovr_pin_drv.sv
module pwm_ovr_pin_drv
  import pwm_ovr_pkg::*;
(
  input  logic            raw_i,
  input  logic            hit_i,
  input  logic [FS_W-1:0] code_i,
  input  logic            pol_i,
  output logic            pin_o,
  output logic            oe_o
);
  logic lvl;
  always_comb begin
    lvl  = raw_i;
    oe_o = 1'b1;
    if (hit_i) begin
      unique case (fs_code_e'(code_i))
        FS_LOW:  lvl = 1'b0;
        FS_HIGH: lvl = 1'b1;
        default: begin
          lvl  = 1'b0;
          oe_o = 1'b0;
        end
      endcase
    end
    // polarity applies to driven levels only; a released pad stays 0
    pin_o = oe_o ? (lvl ^ pol_i) : 1'b0;
  end
endmodule

// File: rtl/pwm_ovr_top.sv
module pwm_ovr_top
  import pwm_ovr_pkg::*;
#(
  parameter int unsigned NUM_SUB   = 4,
  parameter int unsigned NUM_FAULT = 8,
  localparam int unsigned NUM_OUT  = NUM_SUB * CH_PER_SUB
) (
  input  logic [NUM_OUT-1:0]           pwm_raw_i,
  input  logic [NUM_FAULT-1:0]         flt_raw_i,
  input  logic [NUM_FAULT-1:0]         flt_hold_i,
  input  logic [NUM_OUT*NUM_FAULT-1:0] dis_mask_i,
  input  logic [NUM_OUT*FS_W-1:0]      fs_code_i,
  input  logic [NUM_OUT-1:0]           pol_inv_i,
  output logic [NUM_OUT-1:0]           pin_o,
  output logic [NUM_OUT-1:0]           pin_oe_o
);
  // raw input bypasses filter and clock
  logic [NUM_FAULT-1:0] flt_act;
  assign flt_act = flt_raw_i | flt_hold_i;

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    for (genvar c = 0; c < CH_PER_SUB; c++) begin : g_ch
      localparam int unsigned O = s * CH_PER_SUB + c;
      logic hit;

      pwm_ovr_fault_sel #(.NUM_FAULT(NUM_FAULT)) u_sel (
        .flt_act_i (flt_act),
        .mask_i    (dis_mask_i[O*NUM_FAULT +: NUM_FAULT]),
        .hit_o     (hit)
      );

      pwm_ovr_pin_drv u_drv (
        .raw_i  (pwm_raw_i[O]),
        .hit_i  (hit),
        .code_i (fs_code_i[O*FS_W +: FS_W]),
        .pol_i  (pol_inv_i[O]),
        .pin_o  (pin_o[O]),
        .oe_o   (pin_oe_o[O])
      );
    end
  end
endmodule

// File: rtl/pwm_ovr_chk.sv
module pwm_ovr_chk #(
  parameter int unsigned NUM_SUB   = 4,
  parameter int unsigned NUM_FAULT = 8,
  localparam int unsigned NUM_OUT  = NUM_SUB * 3
) (
  input logic [NUM_OUT-1:0]           pwm_raw_i,
  input logic [NUM_FAULT-1:0]         flt_raw_i,
  input logic [NUM_FAULT-1:0]         flt_hold_i,
  input logic [NUM_OUT*NUM_FAULT-1:0] dis_mask_i,
  input logic [NUM_OUT*2-1:0]         fs_code_i,
  input logic [NUM_OUT-1:0]           pol_inv_i,
  input logic [NUM_OUT-1:0]           pin_o,
  input logic [NUM_OUT-1:0]           pin_oe_o
);
  // checks sit on ports only; combinational, so evaluated without a clock (R8)
  always_comb begin
    for (int o = 0; o < NUM_OUT; o++) begin
      logic hit;
      logic [1:0] cd;
      hit = 1'b0;
      for (int f = 0; f < NUM_FAULT; f++)
        if ((flt_raw_i[f] || flt_hold_i[f]) && dis_mask_i[o*NUM_FAULT+f]) hit = 1'b1; // R2 R4
      cd = fs_code_i[o*2 +: 2];
      assert_pass_R1: assert (hit || (pin_oe_o[o] && pin_o[o] == (pwm_raw_i[o] ^ pol_inv_i[o])));
      assert_low_R5:  assert (!(hit && cd == 2'b00) || (pin_oe_o[o] && pin_o[o] == pol_inv_i[o]));
      assert_high_R6: assert (!(hit && cd == 2'b01) || (pin_oe_o[o] && pin_o[o] == !pol_inv_i[o]));
      assert_rel_R7:  assert (!(hit && cd[1]) || (!pin_oe_o[o] && !pin_o[o]));
    end
  end
endmodule

bind pwm_ovr_top pwm_ovr_chk #(.NUM_SUB(NUM_SUB), .NUM_FAULT(NUM_FAULT)) u_chk (.*);

// File: tb/sim_pwm_ovr_top.sv
module sim_pwm_ovr_top;
  localparam int NS = 4;
  localparam int NF = 8;
  localparam int NO = NS * 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [NO-1:0]    pwm_raw;
  logic [NF-1:0]    flt_raw, flt_hold;
  logic [NO*NF-1:0] mask;
  logic [NO*2-1:0]  code;
  logic [NO-1:0]    pol;
  logic [NO-1:0]    pin, oe;

  int errors = 0;
  int checks = 0;

  pwm_ovr_top #(.NUM_SUB(NS), .NUM_FAULT(NF)) u0 (
    .pwm_raw_i(pwm_raw), .flt_raw_i(flt_raw), .flt_hold_i(flt_hold),
    .dis_mask_i(mask), .fs_code_i(code), .pol_inv_i(pol),
    .pin_o(pin), .pin_oe_o(oe)
  );

  // expected outputs from the requirements
  task automatic model(output logic [NO-1:0] ep, output logic [NO-1:0] eo);
    for (int o = 0; o < NO; o++) begin
      logic h;
      h = 1'b0;
      for (int f = 0; f < NF; f++)
        if ((flt_raw[f] | flt_hold[f]) & mask[o*NF+f]) h = 1'b1;
      if (!h)                       begin ep[o] = pwm_raw[o] ^ pol[o]; eo[o] = 1'b1; end
      else if (code[o*2+1])         begin ep[o] = 1'b0;                eo[o] = 1'b0; end
      else if (code[o*2])           begin ep[o] = ~pol[o];             eo[o] = 1'b1; end
      else                          begin ep[o] = pol[o];              eo[o] = 1'b1; end
    end
  endtask

  task automatic check(string req, logic [NO-1:0] ep, logic [NO-1:0] eo);
    checks++;
    if (pin !== ep || oe !== eo) begin
      errors++;
      $display("FAIL %s pin=%h oe=%h expected pin=%h oe=%h", req, pin, oe, ep, eo);
    end
  endtask

  task automatic settle_check(string req);
    logic [NO-1:0] ep, eo;
    #1;
    model(ep, eo);
    check(req, ep, eo);
  endtask

  task automatic defaults();
    pwm_raw = '0; flt_raw = '0; flt_hold = '0;
    mask = '1; code = '0; pol = '0;
  endtask

  task automatic t_reset_cfg();
    @(negedge clk); defaults(); pwm_raw = 12'hA5C;
    settle_check("R1 reset cfg passthrough");
    flt_hold = 8'h10;
    #1; check("R10 reset cfg single fault", '0, '1);
    flt_hold = '0; flt_raw = 8'h01;
    #1; check("R10 reset cfg raw fault", '0, '1);
  endtask

  task automatic t_pass_pol();
    @(negedge clk); defaults();
    pwm_raw = 12'h3C6; pol = 12'h0F0;
    #1; check("R1 polarity passthrough", 12'h3C6 ^ 12'h0F0, '1);
    pwm_raw = 12'hFFF; pol = 12'h555;
    settle_check("R1 pattern two");
  endtask

  task automatic t_codes();
    @(negedge clk); defaults();
    for (int o = 0; o < NO; o++) code[o*2 +: 2] = 2'(o % 4);
    pol = 12'hCC3; pwm_raw = 12'h69A; flt_raw = 8'h80;
    settle_check("R5 R6 R7 mixed codes");
    // explicit output 0: code 00, pol 1 -> pin 1
    if (pin[0] !== 1'b1) begin errors++; $display("FAIL R5 pin0=%b expected 1", pin[0]); end
    checks++;
    // output 1: code 01, pol 1 -> pin 0
    if (pin[1] !== 1'b0) begin errors++; $display("FAIL R6 pin1=%b expected 0", pin[1]); end
    checks++;
    // output 2: code 10, pol 0 -> released
    if (oe[2] !== 1'b0 || pin[2] !== 1'b0) begin errors++; $display("FAIL R7 oe2=%b pin2=%b expected 0 0", oe[2], pin[2]); end
    checks++;
    pol = ~pol;
    settle_check("R7 released ignores polarity");
  endtask

  task automatic t_mask();
    @(negedge clk); defaults();
    mask = '0; code = {NO{2'b01}};
    mask[5*NF+3] = 1'b1; mask[9*NF+6] = 1'b1;
    pwm_raw = 12'h000; flt_raw = 8'h08;
    #1; check("R2 single masked fault", 12'h020, '1);
    flt_raw = 8'hB7;
    #1; check("R3 unmasked faults ignored", 12'h000, '1);
    flt_raw = 8'h48;
    settle_check("R2 two outputs");
  endtask

  task automatic t_sources();
    @(negedge clk); defaults();
    code = {NO{2'b10}}; pwm_raw = 12'hFFF;
    flt_hold = 8'h02;
    #1; check("R4 hold alone", '0, '0);
    flt_hold = '0; flt_raw = 8'h40;
    #1; check("R4 raw alone", '0, '0);
    flt_raw = '0;
    #1; check("R4 none", 12'hFFF, '1);
  endtask

  task automatic t_async();
    @(posedge clk); defaults(); code = {NO{2'b01}};
    #2 flt_raw = 8'h04;
    #1; check("R8 assert between edges", '1, '1);
    flt_raw = '0;
    #1; check("R8 release between edges", '0, '1);
  endtask

  task automatic t_hold_raw();
    @(negedge clk); defaults(); code = {NO{2'b00}}; pol = 12'h00F;
    flt_hold = 8'h01;
    for (int k = 0; k < 4; k++) begin
      pwm_raw = 12'(k * 12'h49B);
      #1; check("R9 raw ignored while held", 12'h00F, '1);
    end
  endtask

  initial begin
    defaults();
    t_reset_cfg();
    t_pass_pol();
    t_codes();
    t_mask();
    t_sources();
    t_async();
    t_hold_raw();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule